// File: doc/BRIEF.md
# Conditional Execution Flag Unit

This block keeps the four result flags (negative, zero, carry, overflow) of a processor pipeline and decides, for each issued instruction, whether that instruction is allowed to take effect. The instruction's 4-bit condition code is tested against the registered flags. The resulting execute-enable is combinational, so it is valid in the same cycle as the condition code.

When an issued instruction passes its condition and asks for a flag update, the flags are reloaded on the next rising edge. Negative and zero are derived here from the datapath result. Carry and overflow come from the arithmetic unit. A separate write strobe lets software load all four flags directly, and it wins over a datapath update in the same cycle.

The block has no data stream with back-pressure. An instruction is considered issued in every cycle where `issue_valid_i` is high, and the block always accepts it. There is no ready signal, and nothing is ever stalled.

Top module: `cc_flag_unit`

## Requirements
- R1: A synchronous, active-high `rst_i` clears all four flags to 0 at the next rising edge, and it wins over every other input. `flags_o` packs the flags as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R2: Condition code 14 (always) gives `exec_o` = 1 and code 15 (never) gives `exec_o` = 0, whatever the flags.
- R3: Single-flag codes: 0 needs Z=1, 1 needs Z=0, 2 needs C=1, 3 needs C=0, 4 needs N=1, 5 needs N=0, 6 needs V=1, 7 needs V=0.
- R4: Unsigned compare codes: 8 needs C=1 and Z=0. 9 needs C=0 or Z=1. Codes 2 and 3 also serve as higher-or-same and lower.
- R5: Signed compare codes: 10 needs N==V, 11 needs N!=V, 12 needs Z=0 and N==V, 13 needs Z=1 or N!=V.
- R6: `exec_o` depends only on `cond_i` and the registered flags. It is valid in the same cycle as `cond_i`, without waiting for a clock edge.
- R7: When `issue_valid_i`, `exec_o` and `set_flags_i` are all 1 and `flag_wr_i` is 0, the flags take the following values at the next edge:
  - N = the most significant bit of `result_i`;
  - Z = 1 exactly when `result_i` is all zero;
  - C = `carry_i`;
  - V = `ovf_i`.
- R8: An issued, executing instruction with `set_flags_i` = 0 leaves all four flags unchanged.
- R9: An instruction whose condition fails leaves the flags unchanged, even when `set_flags_i` = 1.
- R10: `flag_wr_i` = 1 loads `flag_wdata_i` (same bit layout as R1) into the flags at the next edge. It takes priority over a datapath update in the same cycle.
- R11: With `issue_valid_i` = 0, `set_flags_i` has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| issue_valid_i | input | 1 | An instruction is issued this cycle |
| cond_i | input | 4 | Condition code of the issued instruction |
| set_flags_i | input | 1 | Instruction requests a flag update |
| result_i | input | DATA_W | Datapath result used for N and Z |
| carry_i | input | 1 | Carry out from the datapath |
| ovf_i | input | 1 | Signed overflow from the datapath |
| flag_wr_i | input | 1 | Direct flag load strobe |
| flag_wdata_i | input | 4 | Value for the direct load (N,Z,C,V from bit 3 down) |
| exec_o | output | 1 | Instruction may execute |
| flags_o | output | 4 | Registered flags (N,Z,C,V from bit 3 down) |

## Verification
All sixteen condition codes are tried against all sixteen flag states, which are set up through the direct-load strobe. This separates every condition from its inverse partner, and it separates the unsigned group from the signed group, because those two groups disagree only when the overflow or negative flag is involved.

Directed updates then use the following results:
- a zero result;
- a result with only the top bit set;
- results combined with carry and overflow.

These show whether N and Z are taken from the correct bits. Further directed cases cover a failing condition with a set-flags request, a missing issue-valid, and a direct load colliding with an update; these separate the gating terms from one another. A long random run then compares both outputs against a behavioural model on every cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int FLAG_W = 4;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  logic [3:0] cond,
  input  flags_t     f,
  output logic       pass
);
  logic base;

  // Even codes hold the base test; the odd partner is its inverse.
  always_comb begin
    unique case (cond[3:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = (f.n == f.v);
      3'd6:    base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
  end

  assign pass = base ^ cond[0];
endmodule

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              ovf,
  output flags_t            nf
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    nf.n = result[MSB];
    nf.z = (result == '0);
    nf.c = carry;
    nf.v = ovf;
  end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  flags_t wr_val,
  input  logic   upd_en,
  input  flags_t upd_val,
  output flags_t q
);
  logic [FLAG_W-1:0] q_bits;
  logic [FLAG_W-1:0] wr_bits;
  logic [FLAG_W-1:0] upd_bits;

  assign wr_bits  = wr_val;
  assign upd_bits = upd_val;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q_bits[i] <= 1'b0;
      else if (wr_en)  q_bits[i] <= wr_bits[i];
      else if (upd_en) q_bits[i] <= upd_bits[i];
    end
  end

  assign q = q_bits;
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              issue_valid_i,
  input  logic [3:0]        cond_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              flag_wr_i,
  input  logic [3:0]        flag_wdata_i,
  output logic              exec_o,
  output logic [3:0]        flags_o
);
  flags_t cur_flags;
  flags_t new_flags;
  flags_t wr_flags;
  logic   pass;
  logic   upd_en;

  assign wr_flags = flag_wdata_i;

  cc_cond_eval u_eval (
    .cond (cond_i),
    .f    (cur_flags),
    .pass (pass)
  );

  cc_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .result (result_i),
    .carry  (carry_i),
    .ovf    (ovf_i),
    .nf     (new_flags)
  );

  assign upd_en = issue_valid_i & pass & set_flags_i;

  cc_flag_reg u_reg (
    .clk     (clk),
    .rst     (rst_i),
    .wr_en   (flag_wr_i),
    .wr_val  (wr_flags),
    .upd_en  (upd_en),
    .upd_val (new_flags),
    .q       (cur_flags)
  );

  assign exec_o  = pass;
  assign flags_o = cur_flags;
endmodule

// File: rtl/cc_flag_unit_chk.sv
module cc_flag_unit_chk
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_i,
  input logic              issue_valid_i,
  input logic [3:0]        cond_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] result_i,
  input logic              carry_i,
  input logic              ovf_i,
  input logic              flag_wr_i,
  input logic [3:0]        flag_wdata_i,
  input logic              exec_o,
  input logic [3:0]        flags_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst_i |=> flags_o == 4'h0);

  // R2
  always_exec_chk: assert property (@(posedge clk) disable iff (rst_i)
    cond_i == CC_AL |-> exec_o);

  // R2
  never_exec_chk: assert property (@(posedge clk) disable iff (rst_i)
    cond_i == CC_NV |-> !exec_o);

  // R8
  no_set_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!flag_wr_i && !set_flags_i) |=> $stable(flags_o));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!flag_wr_i && !exec_o) |=> $stable(flags_o));

  // R11
  no_issue_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!flag_wr_i && !issue_valid_i) |=> $stable(flags_o));

  // R10
  direct_load_chk: assert property (@(posedge clk) disable iff (rst_i)
    flag_wr_i |=> flags_o == $past(flag_wdata_i));

  // R7
  update_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!flag_wr_i && issue_valid_i && exec_o && set_flags_i) |=>
      flags_o == {$past(result_i[DATA_W-1]), $past(result_i == '0),
                  $past(carry_i), $past(ovf_i)});
endmodule

bind cc_flag_unit cc_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_i         (rst_i),
  .issue_valid_i (issue_valid_i),
  .cond_i        (cond_i),
  .set_flags_i   (set_flags_i),
  .result_i      (result_i),
  .carry_i       (carry_i),
  .ovf_i         (ovf_i),
  .flag_wr_i     (flag_wr_i),
  .flag_wdata_i  (flag_wdata_i),
  .exec_o        (exec_o),
  .flags_o       (flags_o)
);

// File: tb/sim_cc_flag_unit.sv
module sim_cc_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_i = 1'b1;
  logic              issue_valid_i = 1'b0;
  logic [3:0]        cond_i = 4'd14;
  logic              set_flags_i = 1'b0;
  logic [DATA_W-1:0] result_i = '0;
  logic              carry_i = 1'b0;
  logic              ovf_i = 1'b0;
  logic              flag_wr_i = 1'b0;
  logic [3:0]        flag_wdata_i = 4'h0;
  logic              exec_o;
  logic [3:0]        flags_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  bit    mn, mz, mc, mv;
  string flag_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_flag_unit #(.DATA_W(DATA_W)) u0 (.*);

  function automatic bit model_pass(int c, bit n, bit z, bit cy, bit v);
    case (c)
      0:  return z;
      1:  return !z;
      2:  return cy;
      3:  return !cy;
      4:  return n;
      5:  return !n;
      6:  return v;
      7:  return !v;
      8:  return cy && !z;
      9:  return !cy || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string exec_tag(int c);
    if (c >= 14) return "R2";
    if (c == 2 || c == 3 || c == 8 || c == 9) return "R4";
    if (c < 8) return "R3";
    return "R5";
  endfunction

  // One cycle: inputs are applied at the falling edge, exec_o is checked
  // in the same cycle (R6), the model advances at the rising edge and the
  // flags are compared at the following falling edge.
  task automatic cyc(bit rst, bit vld, int c, bit sf, logic [DATA_W-1:0] res,
                     bit cy, bit ov, bit wr, logic [3:0] wd);
    bit    exp_exec;
    bit    exp_n, exp_z;
    string tg;
    @(negedge clk);
    rst_i = rst; issue_valid_i = vld; cond_i = 4'(c); set_flags_i = sf;
    result_i = res; carry_i = cy; ovf_i = ov; flag_wr_i = wr; flag_wdata_i = wd;
    #1;
    exp_exec = model_pass(c, mn, mz, mc, mv);
    if (!rst) begin
      tg = exec_tag(c);
      n_checks++;
      if (exec_o !== exp_exec) begin
        n_fail++;
        $display("FAIL %s/R6 exec_o cond=%0d flags=%b%b%b%b act=%b exp=%b",
                 tg, c, mn, mz, mc, mv, exec_o, exp_exec);
      end
    end
    @(posedge clk);
    exp_n = res[DATA_W-1];
    exp_z = (res == '0);
    if (rst) begin
      {mn, mz, mc, mv} = 4'h0; flag_tag = "R1";
    end else if (wr) begin
      {mn, mz, mc, mv} = wd; flag_tag = "R10";
    end else if (!vld) begin
      flag_tag = "R11";
    end else if (!exp_exec) begin
      flag_tag = "R9";
    end else if (!sf) begin
      flag_tag = "R8";
    end else begin
      mn = exp_n; mz = exp_z; mc = cy; mv = ov; flag_tag = "R7";
    end
    @(negedge clk);
    n_checks++;
    if (flags_o !== {mn, mz, mc, mv}) begin
      n_fail++;
      $display("FAIL %s flags_o act=%b exp=%b", flag_tag, flags_o, {mn, mz, mc, mv});
    end
  endtask

  task automatic load(logic [3:0] wd);
    cyc(0, 0, 14, 0, '0, 0, 0, 1, wd);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    {mn, mz, mc, mv} = 4'hF;
    // R1: reset from an arbitrary state
    cyc(1, 1, 14, 1, 32'h8000_0000, 1, 1, 1, 4'hF);
    cyc(1, 0, 14, 0, '0, 0, 0, 0, 4'h0);
    // R2 R3 R4 R5: every condition against every flag state
    for (int f = 0; f < 16; f++) begin
      load(4'(f));
      for (int c = 0; c < 16; c++) cyc(0, 1, c, 0, 32'h1, 1, 1, 0, 4'h0);
    end
    // R7: zero result, top-bit-only result, carry and overflow
    load(4'h0);
    cyc(0, 1, 14, 1, 32'h0000_0000, 0, 0, 0, 4'h0);
    cyc(0, 1, 14, 1, 32'h8000_0000, 1, 0, 0, 4'h0);
    cyc(0, 1, 14, 1, 32'h7FFF_FFFF, 0, 1, 0, 4'h0);
    cyc(0, 1, 14, 1, 32'h0000_0001, 1, 1, 0, 4'h0);
    // R9: failing condition with a set-flags request
    load(4'h0);
    cyc(0, 1, 0, 1, 32'h8000_0000, 1, 1, 0, 4'h0);
    cyc(0, 1, 15, 1, 32'h0, 1, 1, 0, 4'h0);
    // R11: set-flags without issue
    cyc(0, 0, 14, 1, 32'h0, 1, 1, 0, 4'h0);
    // R8: executing without set-flags
    cyc(0, 1, 14, 0, 32'h0, 1, 1, 0, 4'h0);
    // R10: direct load collides with an update
    cyc(0, 1, 14, 1, 32'h0, 1, 1, 1, 4'b1010);
    cyc(0, 1, 14, 1, 32'h8000_0000, 0, 0, 1, 4'b0101);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      logic [DATA_W-1:0] res = (r < 15) ? '0 : DATA_W'($urandom);
      cyc(r == 0, ($urandom_range(0, 7) != 0), int'($urandom_range(0, 15)),
          1'($urandom), res, 1'($urandom), 1'($urandom),
          ($urandom_range(0, 9) == 0), 4'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule